// File: doc/BRIEF.md
# Blanked Fixed-Off-Time Current Chopper

This block is the digital half of a current regulator for one H-bridge winding. An external comparator raises a flag when the amplified sense-resistor voltage rises above the reference. That flag means the winding current has passed its target. The block turns that flag into a bridge-enable output and a decay indication. While the block is enabled it repeats a fixed cycle:

- The bridge turns on.
- A programmable blanking window hides the switching spike from the comparator.
- The bridge then stays on until an overcurrent is seen.
- The bridge is then cut off for a programmable off-time while the current decays.
- The bridge turns on again.

The comparator flag arrives asynchronously and passes through a two-stage synchronizer. Once the synchronized flag is high outside blanking, the bridge enable drops combinationally in that same cycle. Each accepted trip gives a one-cycle pulse and advances a saturating event counter. There is no data stream here. All pins are plain control and status levels, so no valid/ready handshake or back-pressure applies.

Top module: `current_chopper`

## Requirements
- R1: While reset is held and just after it is released, with the run input low, bridge_on, decaying and trip_pulse are 0 and trip_count is 0.
- R2: When run is seen high at a clock edge while idle, bridge_on is 1 from that edge and a blanking window starts.
- R3: Blanking lasts blank_len clock cycles, and a value of 0 counts as 1. Throughout blanking bridge_on stays 1 and no trip is taken, whatever oc_async does.
- R4: After blanking, oc_async passes through two flip-flops. bridge_on falls in the same cycle as the synchronized flag, which is two clock edges after oc_async rises.
- R5: trip_pulse is high for exactly one cycle per accepted trip, and that is the cycle in which bridge_on falls.
- R6: After a trip, decaying is 1 and bridge_on is 0 for off_len cycles, and a value of 0 counts as 1. Then bridge_on returns to 1 with a new blanking window and decaying returns to 0.
- R7: If the synchronized flag is already high when blanking ends, bridge_on is 0 in the first cycle after blanking, and that trip counts.
- R8: When run is low, bridge_on, decaying and trip_pulse are 0 at once, without waiting for a clock edge. The block returns to idle at the next edge and trip_count keeps its value.
- R9: trip_count adds one per accepted trip and holds at its all-ones maximum.
- R10: While run stays high the on/blank/decay cycle repeats on its own. With oc_async held high, a trip occurs every three cycles when both lengths are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Global enable; low forces idle with the bridge off |
| oc_async | input | 1 | Overcurrent comparator flag, asynchronous |
| blank_len | input | BLANK_W | Blanking length in cycles, loaded at each bridge turn-on |
| off_len | input | OFF_W | Decay length in cycles, loaded at each trip |
| bridge_on | output | 1 | Bridge enable |
| decaying | output | 1 | High during the timed decay |
| trip_pulse | output | 1 | One-cycle pulse per accepted trip |
| trip_count | output | CNT_W | Saturating count of accepted trips |

## Verification
The hardest case to reach is an overcurrent flag that is already high in the last blanking cycle. The flag must be masked up to that cycle and must take effect in the very next one. The synchronizer delay makes the timing of the raw input unobvious. The stimulus raises oc_async on the first drive after turn-on with a three-cycle window, and keeps it high so that the synchronized flag covers the end of blanking. A zero-length blanking window with the flag held high then checks the case where the trip lands on the first ON cycle. Saturation is reached with both lengths set to zero and the flag held high, which packs a trip into every third cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_ON    = 2'd2,
    ST_DECAY = 2'd3
  } chop_state_e;
endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int BLANK_W = 8,
  parameter int OFF_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               oc,
  input  logic [BLANK_W-1:0] blank_len,
  input  logic [OFF_W-1:0]   off_len,
  output logic               bridge_on,
  output logic               decaying,
  output logic               trip
);
  localparam int TW = (BLANK_W > OFF_W) ? BLANK_W : OFF_W;

  chop_state_e   state;
  logic [TW-1:0] cnt;
  logic          last;

  assign last = (cnt <= TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (!run) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state <= ST_BLANK;
          cnt   <= TW'(blank_len);
        end
        ST_BLANK: begin
          if (last) state <= ST_ON;
          else      cnt   <= cnt - TW'(1);
        end
        ST_ON: begin
          if (oc) begin
            state <= ST_DECAY;
            cnt   <= TW'(off_len);
          end
        end
        ST_DECAY: begin
          if (last) begin
            state <= ST_BLANK;
            cnt   <= TW'(blank_len);
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Combinational cut: the trip removes the enable in the cycle it is seen
  assign trip      = run && (state == ST_ON) && oc;
  assign bridge_on = run && ((state == ST_BLANK) || ((state == ST_ON) && !oc));
  assign decaying  = run && (state == ST_DECAY);

  // R3: blanking masks the comparator completely
  a_r3_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == ST_BLANK) |-> (bridge_on && !trip));

  // R4: a trip moves the machine into the decay phase
  a_r4_trip_to_decay: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (state == ST_DECAY || !run));

  // R5: the trip pulse never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !trip);

  // R6: the final decay cycle hands over to a new blanking window
  a_r6_decay_to_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == ST_DECAY && last) |=> (state == ST_BLANK || !run));

  // R8: disable forces idle at the next edge
  a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (state == ST_IDLE));

  a_r8_disable_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!bridge_on && !decaying && !trip));
endmodule

// File: rtl/chop_trip_count.sv
module chop_trip_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                     count <= '0;
    else if (trip && count != MAXV) count <= count + CNT_W'(1);
  end

  // R9: increment by one per trip below the ceiling
  a_r9_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && count != MAXV) |=> (count == $past(count) + CNT_W'(1)));

  // R9: the ceiling holds
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV) |=> (count == MAXV));
endmodule

// File: rtl/current_chopper.sv
module current_chopper #(
  parameter int BLANK_W     = 8,
  parameter int OFF_W       = 10,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               oc_async,
  input  logic [BLANK_W-1:0] blank_len,
  input  logic [OFF_W-1:0]   off_len,
  output logic               bridge_on,
  output logic               decaying,
  output logic               trip_pulse,
  output logic [CNT_W-1:0]   trip_count
);
  logic oc_sync;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (oc_async),
    .q     (oc_sync)
  );

  chop_fsm #(.BLANK_W(BLANK_W), .OFF_W(OFF_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .oc        (oc_sync),
    .blank_len (blank_len),
    .off_len   (off_len),
    .bridge_on (bridge_on),
    .decaying  (decaying),
    .trip      (trip_pulse)
  );

  chop_trip_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .trip  (trip_pulse),
    .count (trip_count)
  );

  // R4: a trip drops the enable in its own cycle
  a_r4_cut_now: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |-> !bridge_on);

  // R6: bridge and decay are never on together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    decaying |-> !bridge_on);
endmodule

// File: tb/current_chopper_bench.sv
module current_chopper_bench;
  localparam int BW = 8;
  localparam int OW = 10;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run;
  logic          oc_async;
  logic [BW-1:0] blank_len;
  logic [OW-1:0] off_len;
  logic          bridge_on;
  logic          decaying;
  logic          trip_pulse;
  logic [CW-1:0] trip_count;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 0;

  typedef struct {
    bit    chk;
    logic  b;
    logic  d;
    logic  p;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  current_chopper #(.BLANK_W(BW), .OFF_W(OW), .CNT_W(CW), .SYNC_STAGES(2)) u_current_chopper (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .oc_async   (oc_async),
    .blank_len  (blank_len),
    .off_len    (off_len),
    .bridge_on  (bridge_on),
    .decaying   (decaying),
    .trip_pulse (trip_pulse),
    .trip_count (trip_count)
  );

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: applies inputs at a falling edge and queues the outputs expected after the next rising edge
  task automatic drive(logic en, logic oc, bit chk, logic b, logic d, logic p, string tag);
    exp_t it;
    @(negedge clk);
    run      = en;
    oc_async = oc;
    it.chk = chk; it.b = b; it.d = d; it.p = p; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic go_idle();
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 idle");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 idle");
  endtask

  // Monitor: pops the scoreboard once per cycle, after the edge
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (trip_pulse) pulses++;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        if (it.chk) begin
          check({it.tag, " bridge_on"},  int'(bridge_on),  int'(it.b));
          check({it.tag, " decaying"},   int'(decaying),   int'(it.d));
          check({it.tag, " trip_pulse"}, int'(trip_pulse), int'(it.p));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; oc_async = 1'b0;
    blank_len = 8'd4; off_len = 10'd3;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();
    // R1 reset state
    check("R1 bridge_on",  int'(bridge_on),  0);
    check("R1 decaying",   int'(decaying),   0);
    check("R1 trip_pulse", int'(trip_pulse), 0);
    check("R1 trip_count", int'(trip_count), 0);

    // Scenario: blank 4, off 3, noise inside blanking, then a real trip
    drive(1, 0, 1, 1, 0, 0, "R2 turn-on");
    drive(1, 1, 1, 1, 0, 0, "R3 noise masked");
    drive(1, 1, 1, 1, 0, 0, "R3 noise masked");
    drive(1, 0, 1, 1, 0, 0, "R3 noise masked");
    drive(1, 0, 1, 1, 0, 0, "R3 on after blank");
    drive(1, 0, 1, 1, 0, 0, "R4 on");
    drive(1, 1, 1, 1, 0, 0, "R4 sync delay");
    drive(1, 1, 1, 0, 0, 1, "R4 R5 trip cut");
    drive(1, 0, 1, 0, 1, 0, "R6 decay");
    drive(1, 0, 1, 0, 1, 0, "R6 decay");
    drive(1, 0, 1, 0, 1, 0, "R6 decay");
    drive(1, 0, 1, 1, 0, 0, "R6 R10 re-enable");
    settle();
    check("R9 count after one trip", int'(trip_count), 1);

    // R8: immediate disable
    @(negedge clk);
    run = 1'b0;
    #1;
    check("R8 immediate cut", int'(bridge_on), 0);
    go_idle();
    settle();
    check("R8 count kept", int'(trip_count), 1);

    // R7: flag already high when blanking ends (blank 3, off 2)
    blank_len = 8'd3; off_len = 10'd2;
    drive(1, 1, 1, 1, 0, 0, "R7 blank");
    drive(1, 1, 1, 1, 0, 0, "R7 blank");
    drive(1, 1, 1, 1, 0, 0, "R7 blank");
    drive(1, 0, 1, 0, 0, 1, "R7 first on cycle");
    drive(1, 0, 1, 0, 1, 0, "R6 decay");
    drive(1, 0, 1, 0, 1, 0, "R6 decay");
    drive(1, 0, 1, 1, 0, 0, "R6 re-enable");
    go_idle();

    // Zero lengths behave as one cycle
    blank_len = 8'd0; off_len = 10'd0;
    drive(1, 1, 1, 1, 0, 0, "R3 zero blank");
    drive(1, 0, 1, 0, 0, 1, "R3 zero blank trip");
    drive(1, 0, 1, 0, 1, 0, "R6 zero off");
    drive(1, 0, 1, 1, 0, 0, "R6 zero off re-enable");
    go_idle();
    settle();
    check("R9 count after three trips", int'(trip_count), 3);

    // R10: autonomous repetition with the flag held high
    pulses = 0;
    for (int i = 0; i < 30; i++) drive(1, 1, 0, 0, 0, 0, "R10");
    settle();
    check("R10 trips in 30 cycles", pulses, 10);
    check("R9 count 13", int'(trip_count), 13);

    // R9: saturation
    for (int i = 0; i < 15; i++) drive(1, 1, 0, 0, 0, 0, "R9");
    settle();
    check("R9 saturated", int'(trip_count), 15);
    go_idle();
    settle();
    check("R8 R9 count held after disable", int'(trip_count), 15);
    check("R8 bridge off", int'(bridge_on), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule